// File: doc/BRIEF.md
# Polarity-Selectable Serial Register Port

This block is the slave side of a synchronous serial link into a converter's register file. It samples four asynchronous pins (serial clock, serial data in, active-low select and a strapped clock-polarity input) with the system clock. It detects serial clock edges and picks the capture edge and the launch edge from the polarity strap. A host can therefore idle its clock either low or high, and no register has to be set up first.

Every transfer opens with one command byte. The byte says whether the host reads or writes and which register it means. A data phase follows whose length depends on the register chosen. Five registers can be written and read back: control mode (16 bits), filter setup (24), excitation DAC (8), offset (24) and gain (24). Two more can only be read: an 8-bit status word and a 24-bit conversion result, both supplied from outside. The select pin frames a transfer. It may also be tied low for a three-wire link. The serial clock may pause at any point without losing bits.

Top module: `polser_port`

## Requirements
- R1: After reset the registers hold mode 0x0000, filter 0x000010, DAC 0x00, offset 0x800000 and gain 0x400000, and the output enable is low.
- R2: With the polarity strap low, input bits are taken on falling serial clock edges and output bits change on rising edges. The clock idles low.
- R3: With the polarity strap high, input bits are taken on rising edges and output bits change on falling edges. The clock idles high.
- R4: The command byte is sent MSB first. Bit 7 set means read and bit 7 clear means write. Bits 3:0 give the address. Bits 6:4 are ignored.
- R5: Address map and data-phase length: 1 status (8, read only), 2 conversion result (24, read only), 3 mode (16), 4 filter (24), 5 DAC (8), 6 offset (24), 7 gain (24). Data is sent MSB first, and the first read bit appears on the first launch edge after the command byte.
- R6: A write to address 1 or 2 runs its full data phase but changes no register. The port then expects a new command byte.
- R7: Addresses 0 and 8 to 15 have no data phase. The next byte is taken as a new command byte.
- R8: Raising the select pin in the middle of a byte or word discards the partial bits. The next transfer starts with a command byte.
- R9: The serial output enable is low whenever the select pin is high, and high while it is low.
- R10: With select held low, transfers follow one another framed by clock edges only. Gaps of any length between clock pulses lose no bits.
- R11: A written register changes only once the last bit of its data phase has been captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from host (asynchronous) |
| sdiIn | input | 1 | Serial data from host |
| csN | input | 1 | Active-low select |
| polSel | input | 1 | Clock-polarity strap |
| statusIn | input | 8 | Status word presented for reads at address 1 |
| dataIn | input | 24 | Conversion result presented for reads at address 2 |
| sdoOut | output | 1 | Serial data to host |
| sdoEn | output | 1 | Drive enable for the serial output pad |
| modeReg | output | 16 | Mode register contents |
| filtReg | output | 24 | Filter register contents |
| dacReg | output | 8 | DAC register contents |
| offsReg | output | 24 | Offset register contents |
| gainReg | output | 24 | Gain register contents |

## Verification
The properties assume that the serial clock, data and select pins change slowly compared with the system clock. Each level must last several system cycles so that every serial edge passes the two-stage synchroniser before the next one arrives. The bench holds every serial half-period at eight system cycles and changes data only together with the launch edge. It changes the polarity strap only while select is high. The properties therefore never see the spurious edge caused when the idle level changes during an active frame.

// File: rtl/polser_pkg.sv
package polser_pkg;
  localparam int WORD_W = 24;
  localparam int MODE_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = $clog2(WORD_W);

  localparam logic [ADDR_W-1:0] A_STATUS = 4'd1;
  localparam logic [ADDR_W-1:0] A_DATA   = 4'd2;
  localparam logic [ADDR_W-1:0] A_MODE   = 4'd3;
  localparam logic [ADDR_W-1:0] A_FILT   = 4'd4;
  localparam logic [ADDR_W-1:0] A_DAC    = 4'd5;
  localparam logic [ADDR_W-1:0] A_OFFS   = 4'd6;
  localparam logic [ADDR_W-1:0] A_GAIN   = 4'd7;

  localparam logic [MODE_W-1:0] RST_MODE = 16'h0000;
  localparam logic [WORD_W-1:0] RST_FILT = 24'h000010;
  localparam logic [BYTE_W-1:0] RST_DAC  = 8'h00;
  localparam logic [WORD_W-1:0] RST_OFFS = 24'h800000;
  localparam logic [WORD_W-1:0] RST_GAIN = 24'h400000;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic              shiftIn;
    logic              launch;
    logic              loadTx;
    logic              commit;
    logic [ADDR_W-1:0] sel;
  } strobes_t;

  // data phase length in bits; zero means no data phase
  function automatic logic [CNT_W:0] fieldLen(input logic [ADDR_W-1:0] a);
    case (a)
      A_STATUS, A_DAC:                 fieldLen = (CNT_W+1)'(BYTE_W);
      A_MODE:                          fieldLen = (CNT_W+1)'(MODE_W);
      A_DATA, A_FILT, A_OFFS, A_GAIN:  fieldLen = (CNT_W+1)'(WORD_W);
      default:                         fieldLen = '0;
    endcase
  endfunction

  function automatic logic isWritable(input logic [ADDR_W-1:0] a);
    isWritable = (a >= A_MODE) && (a <= A_GAIN);
  endfunction
endpackage

// File: rtl/polser_sync.sv
module polser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic sdiIn,
  input  logic csNIn,
  input  logic polIn,
  output logic sdiS,
  output logic csS,
  output logic capEdge,
  output logic launchEdge
);
  localparam int NSIG = 4;
  // bit order {pol, cs, sdi, sclk}; select resets inactive
  localparam logic [NSIG-1:0] RST_VEC = 4'b0100;

  logic [NSIG-1:0] pipe [STAGES];
  logic [NSIG-1:0] rawVec;
  logic            sclkPrev;
  logic            sclkS, polS, rise, fall;

  assign rawVec = {polIn, csNIn, sdiIn, sclkIn};

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       pipe[s] <= RST_VEC;
        else if (s == 0) pipe[s] <= rawVec;
        else             pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sclkS = pipe[STAGES-1][0];
  assign sdiS  = pipe[STAGES-1][1];
  assign csS   = pipe[STAGES-1][2];
  assign polS  = pipe[STAGES-1][3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end

  assign rise       = sclkS & ~sclkPrev;
  assign fall       = ~sclkS & sclkPrev;
  assign capEdge    = polS ? rise : fall;
  assign launchEdge = polS ? fall : rise;
endmodule

// File: rtl/polser_ctrl.sv
module polser_ctrl
  import polser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              capEdge,
  input  logic              launchEdge,
  input  logic              csS,
  input  logic              sdiS,
  input  logic [3:0]        cmdBits,
  output strobes_t          stb,
  output phase_e            phaseOut,
  output logic [CNT_W-1:0]  bitCntOut
);
  phase_e            phase;
  logic [CNT_W-1:0]  bitCnt;
  logic [CNT_W:0]    len;
  logic [ADDR_W-1:0] addr, cmdAddr;
  logic              rdFlag, cmdRd, endCmd, endData;

  assign cmdAddr = {cmdBits[2:0], sdiS};
  assign cmdRd   = cmdBits[3];
  assign endCmd  = (phase == PH_CMD) && (bitCnt == CNT_W'(BYTE_W-1));
  assign endData = (phase == PH_DATA) && ({1'b0, bitCnt} == len - 1'b1);

  always_comb begin
    stb         = '0;
    stb.shiftIn = capEdge & ~csS;
    stb.launch  = launchEdge & ~csS & (phase == PH_DATA) & rdFlag;
    stb.loadTx  = capEdge & ~csS & endCmd;
    stb.commit  = capEdge & ~csS & endData & ~rdFlag & isWritable(addr);
    stb.sel     = (phase == PH_CMD) ? cmdAddr : addr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_CMD;
      bitCnt <= '0;
      addr   <= '0;
      rdFlag <= 1'b0;
      len    <= '0;
    end else if (csS) begin
      phase  <= PH_CMD;
      bitCnt <= '0;
    end else if (capEdge) begin
      if (endCmd) begin
        bitCnt <= '0;
        addr   <= cmdAddr;
        rdFlag <= cmdRd;
        len    <= fieldLen(cmdAddr);
        phase  <= (fieldLen(cmdAddr) == '0) ? PH_CMD : PH_DATA;
      end else if (endData) begin
        bitCnt <= '0;
        phase  <= PH_CMD;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign phaseOut  = phase;
  assign bitCntOut = bitCnt;
endmodule

// File: rtl/polser_dp.sv
module polser_dp
  import polser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              sdiS,
  input  logic [BYTE_W-1:0] statusIn,
  input  logic [WORD_W-1:0] dataIn,
  output logic [3:0]        cmdBits,
  output logic              sdoOut,
  output logic [MODE_W-1:0] modeReg,
  output logic [WORD_W-1:0] filtReg,
  output logic [BYTE_W-1:0] dacReg,
  output logic [WORD_W-1:0] offsReg,
  output logic [WORD_W-1:0] gainReg
);
  logic [WORD_W-2:0] rxShift;
  logic [WORD_W-1:0] wordNext, txShift, rdVal;
  logic              sdoR;

  assign wordNext = {rxShift, sdiS};
  // read flag sits seven bits back, address low bits three back
  assign cmdBits  = {rxShift[BYTE_W-2], rxShift[2:0]};

  // read values left-aligned so the MSB always leaves first
  always_comb begin
    case (stb.sel)
      A_STATUS: rdVal = {statusIn, {(WORD_W-BYTE_W){1'b0}}};
      A_DATA:   rdVal = dataIn;
      A_MODE:   rdVal = {modeReg, {(WORD_W-MODE_W){1'b0}}};
      A_FILT:   rdVal = filtReg;
      A_DAC:    rdVal = {dacReg, {(WORD_W-BYTE_W){1'b0}}};
      A_OFFS:   rdVal = offsReg;
      A_GAIN:   rdVal = gainReg;
      default:  rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      sdoR    <= 1'b0;
    end else begin
      if (stb.shiftIn) rxShift <= wordNext[WORD_W-2:0];
      if (stb.loadTx) begin
        txShift <= rdVal;
      end else if (stb.launch) begin
        sdoR    <= txShift[WORD_W-1];
        txShift <= {txShift[WORD_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= RST_MODE;
      filtReg <= RST_FILT;
      dacReg  <= RST_DAC;
      offsReg <= RST_OFFS;
      gainReg <= RST_GAIN;
    end else if (stb.commit) begin
      case (stb.sel)
        A_MODE:  modeReg <= wordNext[MODE_W-1:0];
        A_FILT:  filtReg <= wordNext;
        A_DAC:   dacReg  <= wordNext[BYTE_W-1:0];
        A_OFFS:  offsReg <= wordNext;
        A_GAIN:  gainReg <= wordNext;
        default: ;
      endcase
    end
  end

  assign sdoOut = sdoR;
endmodule

// File: rtl/polser_port.sv
module polser_port
  import polser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              sdiIn,
  input  logic              csN,
  input  logic              polSel,
  input  logic [BYTE_W-1:0] statusIn,
  input  logic [WORD_W-1:0] dataIn,
  output logic              sdoOut,
  output logic              sdoEn,
  output logic [MODE_W-1:0] modeReg,
  output logic [WORD_W-1:0] filtReg,
  output logic [BYTE_W-1:0] dacReg,
  output logic [WORD_W-1:0] offsReg,
  output logic [WORD_W-1:0] gainReg
);
  logic             sdiS, csS, capEdge, launchEdge;
  logic [3:0]       cmdBits;
  strobes_t         stb;
  phase_e           ctrlPhase;
  logic [CNT_W-1:0] ctrlBits;

  polser_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdiIn(sdiIn), .csNIn(csN),
    .polIn(polSel), .sdiS(sdiS), .csS(csS), .capEdge(capEdge),
    .launchEdge(launchEdge)
  );

  polser_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .capEdge(capEdge), .launchEdge(launchEdge),
    .csS(csS), .sdiS(sdiS), .cmdBits(cmdBits), .stb(stb),
    .phaseOut(ctrlPhase), .bitCntOut(ctrlBits)
  );

  polser_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiS(sdiS), .statusIn(statusIn),
    .dataIn(dataIn), .cmdBits(cmdBits), .sdoOut(sdoOut), .modeReg(modeReg),
    .filtReg(filtReg), .dacReg(dacReg), .offsReg(offsReg), .gainReg(gainReg)
  );

  assign sdoEn = ~csS;
endmodule

// File: rtl/polser_port_chk.sv
module polser_port_chk
  import polser_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              sdoEn,
  input strobes_t          stb,
  input phase_e            ctrlPhase,
  input logic [CNT_W-1:0]  ctrlBits,
  input logic [MODE_W-1:0] modeReg,
  input logic [WORD_W-1:0] gainReg
);
  // R9: select high two samples back forces the pad undriven
  p_hiz_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN, 2) |-> !sdoEn);

  // R8: select high aborts into the command phase with a cleared count
  p_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN, 3) |-> (ctrlPhase == PH_CMD && ctrlBits == '0));

  // R4: command byte count never passes seven
  p_cmd_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlPhase == PH_CMD) |-> (ctrlBits < CNT_W'(BYTE_W)));

  // R6: commits only ever land on writable addresses
  p_ro_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> (stb.sel >= A_MODE && stb.sel <= A_GAIN));

  // R11: mode and gain move only on their own commit
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.commit && stb.sel == A_MODE) |=> $stable(modeReg));

  p_gain_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.commit && stb.sel == A_GAIN) |=> $stable(gainReg));
endmodule

bind polser_port polser_port_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sdoEn(sdoEn), .stb(stb),
  .ctrlPhase(ctrlPhase), .ctrlBits(ctrlBits), .modeReg(modeReg),
  .gainReg(gainReg)
);

// File: tb/polser_port_tb.sv
module polser_port_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam int NVEC  = 13;

  typedef struct packed {
    logic        pol;
    logic [7:0]  cmd;
    logic [4:0]  nbits;
    logic [23:0] wdata;
    logic [23:0] expv;
    logic        chk;
    logic [3:0]  req;
  } vec_t;

  // R1 reset read-back, R2 polarity low, R3 polarity high,
  // R4 ignored command bits, R5 address map and lengths
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h83, 5'd16, 24'h0,      24'h000000, 1'b1, 4'd1},
    '{1'b0, 8'h86, 5'd24, 24'h0,      24'h800000, 1'b1, 4'd1},
    '{1'b0, 8'h03, 5'd16, 24'h001234, 24'h0,      1'b0, 4'd2},
    '{1'b0, 8'h83, 5'd16, 24'h0,      24'h001234, 1'b1, 4'd2},
    '{1'b0, 8'h81, 5'd8,  24'h0,      24'h0000A5, 1'b1, 4'd5},
    '{1'b0, 8'h82, 5'd24, 24'h0,      24'hC35A96, 1'b1, 4'd5},
    '{1'b1, 8'h04, 5'd24, 24'hABCDEF, 24'h0,      1'b0, 4'd3},
    '{1'b1, 8'h84, 5'd24, 24'h0,      24'hABCDEF, 1'b1, 4'd3},
    '{1'b1, 8'h05, 5'd8,  24'h00005C, 24'h0,      1'b0, 4'd3},
    '{1'b1, 8'h85, 5'd8,  24'h0,      24'h00005C, 1'b1, 4'd3},
    '{1'b0, 8'h07, 5'd24, 24'h0F0F0F, 24'h0,      1'b0, 4'd5},
    '{1'b1, 8'h87, 5'd24, 24'h0,      24'h0F0F0F, 1'b1, 4'd5},
    '{1'b1, 8'hF3, 5'd16, 24'h0,      24'h001234, 1'b1, 4'd4}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkIn = 1'b0, sdiIn = 1'b0, csN = 1'b1, polSel = 1'b0;
  logic [7:0]  statusIn = 8'hA5;
  logic [23:0] dataIn = 24'hC35A96;
  logic        sdoOut, sdoEn;
  logic [15:0] modeReg;
  logic [23:0] filtReg, offsReg, gainReg;
  logic [7:0]  dacReg;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  polser_port u_dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdiIn(sdiIn), .csN(csN),
    .polSel(polSel), .statusIn(statusIn), .dataIn(dataIn), .sdoOut(sdoOut),
    .sdoEn(sdoEn), .modeReg(modeReg), .filtReg(filtReg), .dacReg(dacReg),
    .offsReg(offsReg), .gainReg(gainReg)
  );

  task automatic checkEq(input string tag, input logic [23:0] act,
                         input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit: launch edge, sample before capture, capture edge
  task automatic bitPhase(input logic b, input int gap, output logic got);
    sdiIn  = b;
    sclkIn = ~polSel;
    waitClk(HALF);
    got    = sdoOut;
    sclkIn = polSel;
    waitClk(HALF + gap);
  endtask

  task automatic shiftBits(input int n, input logic [23:0] w, input int gap,
                           output logic [23:0] r);
    logic b;
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bitPhase(w[i], gap, b);
      r = {r[22:0], b};
    end
  endtask

  task automatic openFrame(input logic pol);
    csN    = 1'b1;
    waitClk(4);
    polSel = pol;
    sclkIn = pol;
    waitClk(10);
    csN    = 1'b0;
    waitClk(4);
  endtask

  task automatic closeFrame();
    waitClk(4);
    csN = 1'b1;
    waitClk(6);
  endtask

  task automatic frame(input logic pol, input logic [7:0] cmd, input int n,
                       input logic [23:0] w, output logic [23:0] r);
    logic [23:0] dummy;
    openFrame(pol);
    shiftBits(8, {16'h0, cmd}, 0, dummy);
    shiftBits(n, w, 0, r);
    closeFrame();
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] r;
    logic [23:0] dummy;
    waitClk(5);
    // R1: reset state at the ports
    checkEq("R1 mode", {8'h0, modeReg}, 24'h000000);
    checkEq("R1 filter", filtReg, 24'h000010);
    checkEq("R1 dac", {16'h0, dacReg}, 24'h000000);
    checkEq("R1 offset", offsReg, 24'h800000);
    checkEq("R1 gain", gainReg, 24'h400000);
    checkEq("R1 sdoEn", {23'h0, sdoEn}, 24'h0);
    rstN = 1'b1;
    waitClk(5);

    for (int v = 0; v < NVEC; v++) begin
      frame(VECS[v].pol, VECS[v].cmd, int'(VECS[v].nbits), VECS[v].wdata, r);
      if (VECS[v].chk)
        checkEq($sformatf("R%0d vector %0d", VECS[v].req, v), r, VECS[v].expv);
    end
    checkEq("R5 gain port", gainReg, 24'h0F0F0F);

    // R9: output enable follows select
    csN = 1'b1; waitClk(6);
    checkEq("R9 enable off", {23'h0, sdoEn}, 24'h0);
    csN = 1'b0; waitClk(6);
    checkEq("R9 enable on", {23'h0, sdoEn}, 24'h1);
    csN = 1'b1; waitClk(6);

    // R6: write to status is dropped; next byte is a command
    openFrame(1'b0);
    shiftBits(8, 24'h01, 0, dummy);
    shiftBits(8, 24'hFF, 0, dummy);
    shiftBits(8, 24'h83, 0, dummy);
    shiftBits(16, 24'h0, 0, r);
    closeFrame();
    checkEq("R6 mode after ro write", r, 24'h001234);

    // R7: addresses without a data phase
    openFrame(1'b1);
    shiftBits(8, 24'h00, 0, dummy);
    shiftBits(8, 24'h0A, 0, dummy);
    shiftBits(8, 24'h85, 0, dummy);
    shiftBits(8, 24'h0, 0, r);
    closeFrame();
    checkEq("R7 dac after empty commands", r, 24'h00005C);

    // R8: abort mid data word, then mid command byte
    openFrame(1'b0);
    shiftBits(8, 24'h03, 0, dummy);
    shiftBits(10, 24'h3FF, 0, dummy);
    closeFrame();
    checkEq("R8 mode kept after abort", {8'h0, modeReg}, 24'h001234);
    openFrame(1'b0);
    shiftBits(5, 24'h1F, 0, dummy);
    closeFrame();
    frame(1'b0, 8'h83, 16, 24'h0, r);
    checkEq("R8 read after aborted command", r, 24'h001234);

    // R11: gain changes only on the final bit
    openFrame(1'b1);
    shiftBits(8, 24'h07, 0, dummy);
    shiftBits(23, 24'hA5A5A5 >> 1, 0, dummy);
    checkEq("R11 gain before last bit", gainReg, 24'h0F0F0F);
    shiftBits(1, 24'h1, 0, dummy);
    checkEq("R11 gain after last bit", gainReg, 24'hA5A5A5);
    closeFrame();

    // R10: three-wire with select held low and gaps between pulses
    openFrame(1'b0);
    shiftBits(8, 24'h05, 40, dummy);
    shiftBits(8, 24'h3C, 40, dummy);
    shiftBits(8, 24'h85, 25, dummy);
    shiftBits(8, 24'h0, 25, r);
    checkEq("R10 dac readback", r, 24'h00003C);
    shiftBits(8, 24'h86, 0, dummy);
    shiftBits(24, 24'h0, 13, r);
    checkEq("R10 offset readback", r, 24'h800000);
    closeFrame();
    checkEq("R10 dac port", {16'h0, dacReg}, 24'h00003C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule